// File: doc/BRIEF.md
# Five-Port Wormhole Connection Arbiter

This block is the arbitration and connection-tracking core of a five-port mesh switch. An input port whose header flit has been routed raises a request naming the output it wants, together with the length of its packet in flits. Each cycle the arbiter takes one pending request, chosen by a rotating priority, and looks at the named output. If that output is free, the request becomes a connection. If the output is taken, the request is turned away for this round and can try again later. Granted connections are held in a table that the crossbar reads as a mapping from input to output, and one busy flag per output summarises which outputs are reserved.

A connection stays in place for the whole wormhole packet. The input reports every flit it forwards, and the connection is torn down on the edge where the forwarded count reaches the packet length. Up to five connections can be live at once, one per input, and no output is ever reserved by more than one input.

Top module: `wh_conn_arbiter`

## Requirements
- R1: After reset no connection is live, every output busy flag is clear, and the rotating priority pointer points at input 0.
- R2: A request from an unconnected input to a free, valid output becomes a connection on the next clock edge: that input's valid bit sets, its output field holds the requested output number (0 = first output … 4 = fifth), and that output's busy flag sets.
- R3: At most one new connection is created per clock edge, however many inputs request.
- R4: Among the requesting unconnected inputs, the one served is the first found searching upward from the pointer and wrapping past input 4 to input 0. The pointer then moves to the input just after the one served, whether its request was granted or rejected.
- R5: A request whose output is busy is not granted and leaves the table unchanged. A request that stays asserted is granted in a later round once the output has been released.
- R6: No output is mapped by two live connections, and an output's busy flag is set exactly when some live connection maps to it.
- R7: A live connection is released on the edge where its count of forwarded flits reaches the packet length latched at grant. A latched length of 0 is treated as 1. Until that edge the connection and its output field stay unchanged.
- R8: A flit-forward strobe on an input with no live connection has no effect, and a request from an input that already holds a connection is ignored.
- R9: A request naming an output number of 5 or above is never granted; the served input is only skipped for that round.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 5 | Per input: a routed header is asking for an output |
| req_dest | input | 15 | Per input, 3 bits each: requested output number |
| req_len | input | 40 | Per input, 8 bits each: packet length in flits |
| flit_fire | input | 5 | Per input: one flit forwarded through its connection this cycle |
| conn_valid | output | 5 | Per input: connection is live |
| conn_out | output | 15 | Per input, 3 bits each: output the input is connected to |
| out_busy | output | 5 | Per output: reserved by a live connection |

## Verification
The bench goes after pointer movement on a rejected request. A design that held the pointer on a blocked input would starve the input behind it, and the check of the table one cycle later exposes that. It targets the edge on which a busy output frees up while a blocked requester waits. A design that granted a busy output would map it twice, and one that lost the pending request would never connect. It also covers zero-length packets, out-of-range output numbers, and flit strobes and repeat requests on inputs in the wrong state. An off-by-one in the flit counter would release one cycle early or late, and a missing guard would corrupt a live mapping.

// File: rtl/wh_arb_pkg.sv
package wh_arb_pkg;

   // Advance an index by one, wrapping at n.
   function automatic int wrap_inc(input int v, input int n);
      return (v + 1 >= n) ? 0 : v + 1;
   endfunction

   // Latched length: zero is promoted to one flit.
   function automatic int unsigned eff_len(input int unsigned len);
      return (len == 0) ? 1 : len;
   endfunction

endpackage

// File: rtl/wh_rr_picker.sv
module wh_rr_picker #(
   parameter int N_PORTS = 5,
   parameter int IW      = 3
) (
   input  logic [N_PORTS-1:0] cand,
   input  logic [IW-1:0]      ptr,
   output logic               hit,
   output logic [IW-1:0]      idx
);

   int pos;

   always_comb begin
      hit = 1'b0;
      idx = '0;
      pos = 0;
      for (int k = 0; k < N_PORTS; k++) begin
         pos = int'(ptr) + k;
         if (pos >= N_PORTS) pos = pos - N_PORTS;
         if (!hit && cand[pos]) begin
            hit = 1'b1;
            idx = IW'(pos);
         end
      end
   end

endmodule

// File: rtl/wh_conn_slot.sv
module wh_conn_slot #(
   parameter int IW    = 3,
   parameter int LEN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [IW-1:0]    load_out,
   input  logic [LEN_W-1:0] load_len,
   input  logic             fire,
   output logic             live,
   output logic [IW-1:0]    out_sel
);
   import wh_arb_pkg::*;

   logic [LEN_W-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live    <= 1'b0;
         out_sel <= '0;
         remain  <= '0;
      end else if (load) begin
         live    <= 1'b1;
         out_sel <= load_out;
         remain  <= LEN_W'(eff_len(int'(load_len)));
      end else if (live && fire) begin
         if (remain <= LEN_W'(1)) begin
            live <= 1'b0;
         end else begin
            remain <= remain - LEN_W'(1);
         end
      end
   end

endmodule

// File: rtl/wh_conn_arbiter.sv
module wh_conn_arbiter #(
   parameter int N_PORTS = 5,
   parameter int LEN_W   = 8,
   parameter int PW      = $clog2(N_PORTS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [N_PORTS-1:0]    req_valid,
   input  logic [N_PORTS*PW-1:0] req_dest,
   input  logic [N_PORTS*LEN_W-1:0] req_len,
   input  logic [N_PORTS-1:0]    flit_fire,
   output logic [N_PORTS-1:0]    conn_valid,
   output logic [N_PORTS*PW-1:0] conn_out,
   output logic [N_PORTS-1:0]    out_busy
);
   import wh_arb_pkg::*;

   if (N_PORTS < 2) begin : g_bad_ports
      $error("wh_conn_arbiter: N_PORTS must be at least 2");
   end
   if ((1 << PW) < N_PORTS) begin : g_bad_pw
      $error("wh_conn_arbiter: PW too narrow for N_PORTS");
   end
   if (LEN_W < 1) begin : g_bad_len
      $error("wh_conn_arbiter: LEN_W must be at least 1");
   end

   logic [PW-1:0]      ptr_q;
   logic [N_PORTS-1:0] cand;
   logic               pick_hit;
   logic [PW-1:0]      pick_idx;
   logic [PW-1:0]      pick_dest;
   logic [LEN_W-1:0]   pick_len;
   logic [N_PORTS-1:0] dest_hot;
   logic               grant;
   logic [N_PORTS-1:0] load_vec;

   // Only inputs without a live connection compete.
   assign cand = req_valid & ~conn_valid;

   wh_rr_picker #(.N_PORTS(N_PORTS), .IW(PW)) u_pick (
      .cand (cand),
      .ptr  (ptr_q),
      .hit  (pick_hit),
      .idx  (pick_idx)
   );

   always_comb begin
      pick_dest = '0;
      pick_len  = '0;
      for (int i = 0; i < N_PORTS; i++) begin
         if (pick_idx == PW'(i)) begin
            pick_dest = req_dest[i*PW +: PW];
            pick_len  = req_len[i*LEN_W +: LEN_W];
         end
      end
   end

   // One-hot decode of the requested output; empty when out of range.
   always_comb begin
      for (int o = 0; o < N_PORTS; o++) begin
         dest_hot[o] = (pick_dest == PW'(o));
      end
   end

   assign grant = pick_hit && (|dest_hot) && !(|(dest_hot & out_busy));

   always_comb begin
      for (int i = 0; i < N_PORTS; i++) begin
         load_vec[i] = grant && (pick_idx == PW'(i));
      end
   end

   // Pointer moves past the served input on grant and on reject alike.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (pick_hit) begin
         ptr_q <= PW'(wrap_inc(int'(pick_idx), N_PORTS));
      end
   end

   for (genvar g = 0; g < N_PORTS; g++) begin : g_slot
      wh_conn_slot #(.IW(PW), .LEN_W(LEN_W)) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (load_vec[g]),
         .load_out (pick_dest),
         .load_len (pick_len),
         .fire     (flit_fire[g]),
         .live     (conn_valid[g]),
         .out_sel  (conn_out[g*PW +: PW])
      );
   end

   // Busy flags are a view of the connection table.
   always_comb begin
      out_busy = '0;
      for (int o = 0; o < N_PORTS; o++) begin
         for (int i = 0; i < N_PORTS; i++) begin
            if (conn_valid[i] && conn_out[i*PW +: PW] == PW'(o)) out_busy[o] = 1'b1;
         end
      end
   end

endmodule

// File: rtl/wh_conn_arbiter_chk.sv
module wh_conn_arbiter_chk #(
   parameter int N_PORTS = 5,
   parameter int PW      = 3
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [N_PORTS-1:0]    req_valid,
   input logic [N_PORTS*PW-1:0] req_dest,
   input logic [N_PORTS-1:0]    flit_fire,
   input logic [N_PORTS-1:0]    conn_valid,
   input logic [N_PORTS*PW-1:0] conn_out,
   input logic [N_PORTS-1:0]    out_busy
);

   // R3: never more than one fresh connection per edge.
   a_r3_one_new: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(conn_valid & ~$past(conn_valid)) <= 1);

   for (genvar o = 0; o < N_PORTS; o++) begin : g_out
      logic [N_PORTS-1:0] owners;
      for (genvar i = 0; i < N_PORTS; i++) begin : g_in
         assign owners[i] = conn_valid[i] && (conn_out[i*PW +: PW] == PW'(o));
      end
      // R6: exclusive ownership and busy flag agreement.
      a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(owners));
      a_r6_busy_flag: assert property (@(posedge clk) disable iff (!rst_n)
         out_busy[o] == (|owners));
   end

   for (genvar i = 0; i < N_PORTS; i++) begin : g_conn
      // R2: a new connection matches the request seen one edge before.
      a_r2_grant_dest: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(conn_valid[i]) |->
            ($past(req_valid[i]) && $past(req_dest[i*PW +: PW]) == conn_out[i*PW +: PW]));
      // R5: a grant never lands on an output that was busy.
      a_r5_free_only: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(conn_valid[i]) |->
            (($past(out_busy) >> conn_out[i*PW +: PW]) & 1) == 0);
      // R7: without a forwarded flit the connection holds unchanged.
      a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
         (conn_valid[i] && !flit_fire[i]) |=>
            (conn_valid[i] && $stable(conn_out[i*PW +: PW])));
      // R9: the stored output number is always in range.
      a_r9_range: assert property (@(posedge clk) disable iff (!rst_n)
         conn_valid[i] |-> (int'(conn_out[i*PW +: PW]) < N_PORTS));
   end

endmodule

bind wh_conn_arbiter wh_conn_arbiter_chk #(.N_PORTS(N_PORTS), .PW(PW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_dest   (req_dest),
   .flit_fire  (flit_fire),
   .conn_valid (conn_valid),
   .conn_out   (conn_out),
   .out_busy   (out_busy)
);

// File: tb/wh_conn_arbiter_tb_top.sv
`timescale 1ns/1ps
module wh_conn_arbiter_tb_top;
   localparam int N  = 5;
   localparam int PW = 3;
   localparam int LW = 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [N-1:0]    req_valid = '0;
   logic [N*PW-1:0] req_dest = '0;
   logic [N*LW-1:0] req_len = '0;
   logic [N-1:0]    flit_fire = '0;
   logic [N-1:0]    conn_valid;
   logic [N*PW-1:0] conn_out;
   logic [N-1:0]    out_busy;

   int checks = 0;
   int fails  = 0;

   // Reference state built from the requirements.
   bit m_v [N];
   int m_o [N];
   int m_r [N];
   int m_p;

   always #4 clk = ~clk;

   wh_conn_arbiter #(.N_PORTS(N), .LEN_W(LW)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dest(req_dest),
      .req_len(req_len), .flit_fire(flit_fire), .conn_valid(conn_valid),
      .conn_out(conn_out), .out_busy(out_busy)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int slot_out(input int i);
      return int'(conn_out[i*PW +: PW]);
   endfunction

   function automatic int model_valid_vec();
      int v = 0;
      for (int i = 0; i < N; i++) if (m_v[i]) v |= (1 << i);
      return v;
   endfunction

   function automatic int model_busy_vec();
      int b = 0;
      for (int i = 0; i < N; i++) if (m_v[i]) b |= (1 << m_o[i]);
      return b;
   endfunction

   task automatic set_req(input int i, input bit v, input int d, input int len);
      req_valid[i] = v;
      req_dest[i*PW +: PW] = PW'(d);
      req_len[i*LW +: LW] = LW'(len);
   endtask

   task automatic clear_inputs();
      req_valid = '0; req_dest = '0; req_len = '0; flit_fire = '0;
   endtask

   task automatic model_reset();
      for (int i = 0; i < N; i++) begin m_v[i] = 0; m_o[i] = 0; m_r[i] = 0; end
      m_p = 0;
   endtask

   // One clock: compute model next state from present inputs, advance, compare.
   task automatic cycle();
      bit nv [N]; int no [N]; int nr [N]; int np;
      int sel, d, bsy;
      sel = -1;
      bsy = model_busy_vec();
      for (int k = 0; k < N; k++) begin
         int c = (m_p + k) % N;
         if (sel < 0 && req_valid[c] && !m_v[c]) sel = c;
      end
      for (int i = 0; i < N; i++) begin
         nv[i] = m_v[i]; no[i] = m_o[i]; nr[i] = m_r[i];
         if (m_v[i] && flit_fire[i]) begin
            if (m_r[i] <= 1) nv[i] = 0; else nr[i] = m_r[i] - 1;
         end
      end
      np = m_p;
      if (sel >= 0) begin
         d = int'(req_dest[sel*PW +: PW]);
         if (d < N && ((bsy >> d) & 1) == 0) begin
            nv[sel] = 1; no[sel] = d;
            nr[sel] = (req_len[sel*LW +: LW] == 0) ? 1 : int'(req_len[sel*LW +: LW]);
         end
         np = (sel + 1) % N;
      end
      @(posedge clk);
      @(negedge clk);
      for (int i = 0; i < N; i++) begin m_v[i] = nv[i]; m_o[i] = no[i]; m_r[i] = nr[i]; end
      m_p = np;
      chk("R4 table valid vs model", int'(conn_valid), model_valid_vec());
      chk("R6 busy flags vs model", int'(out_busy), model_busy_vec());
      for (int i = 0; i < N; i++) begin
         if (m_v[i]) chk("R2 output field vs model", slot_out(i), m_o[i]);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      clear_inputs();
      model_reset();
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      do_reset();
      // R1: reset state
      chk("R1 no live connection", int'(conn_valid), 0);
      chk("R1 busy clear", int'(out_busy), 0);

      // R2 / R7: single grant then release after three flits
      set_req(2, 1, 4, 3);
      cycle();
      chk("R2 valid", int'(conn_valid), 5'b00100);
      chk("R2 output field", slot_out(2), 4);
      chk("R2 busy", int'(out_busy), 5'b10000);
      set_req(2, 0, 0, 0);
      flit_fire[2] = 1'b1;
      cycle(); cycle();
      chk("R7 held before last flit", int'(conn_valid), 5'b00100);
      cycle();
      chk("R7 released on last flit", int'(conn_valid), 0);
      chk("R7 busy cleared", int'(out_busy), 0);
      flit_fire = '0;

      // R3 / R4: three simultaneous requests served in pointer order
      do_reset();
      set_req(1, 1, 0, 4); set_req(3, 1, 2, 4); set_req(4, 1, 3, 4);
      cycle();
      chk("R3 one grant per edge", int'(conn_valid), 5'b00010);
      cycle();
      chk("R4 next from pointer", int'(conn_valid), 5'b01010);
      cycle();
      chk("R4 wrap order", int'(conn_valid), 5'b11010);

      // R4: pointer advances past a rejected input
      do_reset();
      set_req(0, 1, 2, 5);
      cycle();
      set_req(0, 0, 0, 0);
      set_req(1, 1, 2, 3); set_req(2, 1, 3, 3);
      cycle();
      chk("R4 rejected input served, no grant", int'(conn_valid), 5'b00001);
      cycle();
      chk("R4 pointer moved past rejected input", int'(conn_valid), 5'b00101);
      chk("R4 granted output", slot_out(2), 3);

      // R5: blocked request waits, then is granted after release
      do_reset();
      set_req(0, 1, 1, 1);
      cycle();
      set_req(0, 0, 0, 0);
      set_req(2, 1, 1, 2);
      cycle();
      chk("R5 blocked, table unchanged", int'(conn_valid), 5'b00001);
      flit_fire[0] = 1'b1;
      cycle();
      flit_fire = '0;
      chk("R5 owner released, still no grant", int'(conn_valid), 5'b00000);
      cycle();
      chk("R5 retried and granted", int'(conn_valid), 5'b00100);
      chk("R5 granted output", slot_out(2), 1);

      // R7: length zero behaves as one flit
      do_reset();
      set_req(1, 1, 3, 0);
      cycle();
      set_req(1, 0, 0, 0);
      chk("R7 zero length granted", int'(conn_valid), 5'b00010);
      flit_fire[1] = 1'b1;
      cycle();
      flit_fire = '0;
      chk("R7 zero length released after one flit", int'(conn_valid), 0);

      // R9 / R8: out-of-range output, stray strobes, repeat request
      do_reset();
      set_req(0, 1, 5, 2);
      flit_fire = '1;
      cycle();
      chk("R9 out-of-range output not granted", int'(conn_valid), 0);
      chk("R8 stray strobes no effect", int'(out_busy), 0);
      clear_inputs();
      set_req(3, 1, 0, 2);
      cycle();
      set_req(3, 1, 1, 2);
      cycle(); cycle();
      chk("R8 repeat request ignored, output kept", slot_out(3), 0);
      chk("R8 repeat request ignored, busy kept", int'(out_busy), 5'b00001);

      // Random traffic against the model (R2..R9)
      do_reset();
      for (int n = 0; n < 3000; n++) begin
         for (int i = 0; i < N; i++) begin
            set_req(i, ($urandom % 3) == 0, int'($urandom % 6), int'($urandom % 5));
            flit_fire[i] = ($urandom % 2) == 1;
         end
         cycle();
      end
      clear_inputs();

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule